// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block holds the interrupt state of a serial peripheral behind a small register window. Seven interrupt causes are each latched into a sticky status bit. A mask decides which of the latched causes may raise the single interrupt request line. Two kinds of cause feed the bank. Pulse causes, such as a mode fault, set their bit once. Level causes, such as receive data present, set their bit on every clock while the condition lasts.

Software never writes the mask directly. A write to the arm register turns on the mask bits that carry a 1 in the write data. A write to the disarm register turns off the mask bits that carry a 1. A read-only view shows the resulting mask. Writing 1s to the status register clears the matching latched causes. After reset, a host driver normally disarms all seven causes and clears all status bits before it uses the bank. The bit meanings are fixed: bit 1 is mode fault, bit 2 is transmit below watermark, bit 3 is transmit full and bit 4 is receive not empty. The other bits are spare causes.

Top module: `spi_irq_regbank`

## Requirements
- R1: After a synchronous reset, status, mask, `irq` and `rdata` are all zero.
- R2: A 1 on `evt_pulse[i]` in a cycle makes status bit i read back as 1, and the bit stays set until it is cleared by software.
- R3: A write to offset 0x04 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If a cause for bit i arrives in the same cycle as a write that clears bit i, status bit i remains set.
- R5: While `lvl_src[i]` is high, status bit i sets again on every clock, so a clear written during that time leaves it set. Once the level drops, a clear removes the bit.
- R6: A write to offset 0x08 sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R7: A write to offset 0x0C clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R8: A read of offset 0x04 returns the status bits, and a read of offset 0x10 returns the mask bits. Both appear in bits 6:0 of `rdata` one clock after `rd_en`.
- R9: A read of offset 0x08, offset 0x0C or any unmapped offset returns zero.
- R10: `irq` is 1 exactly when some bit is set in both the status and the mask, in the same cycle those registers hold the values.
- R11: A write to offset 0x10 or to an unmapped offset changes neither the mask nor the status.
- R12: Write-data bits at positions 7 and above have no effect, and read-data bits at those positions are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after `rd_en` |
| evt_pulse | input | 7 | Pulse causes; each sets its status bit |
| lvl_src | input | 7 | Level causes; each sets its status bit every cycle it is high |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the bank with its default parameters: seven causes, an 8-bit offset and a 32-bit data path. With a 32-bit data path, the bench can write 1s above bit 6 and show that they are dropped. It can also read offsets with no register behind them. Seven causes let the tests mix set, armed and disarmed bits in a single status or mask word. This shows that each bit keeps its own state. The directed tests then cover a clear that collides with an arriving cause, and a level cause held across a clear.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // Register offsets; software depends on these fixed positions.
  localparam int unsigned OFS_STATUS = 32'h04;
  localparam int unsigned OFS_ARM    = 32'h08;
  localparam int unsigned OFS_DISARM = 32'h0C;
  localparam int unsigned OFS_MASKRD = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ARM,
    SEL_DISARM,
    SEL_MASKRD
  } reg_sel_e;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (ADDR_W'(OFS_STATUS) == addr)      sel = SEL_STATUS;
    else if (ADDR_W'(OFS_ARM) == addr)    sel = SEL_ARM;
    else if (ADDR_W'(OFS_DISARM) == addr) sel = SEL_DISARM;
    else if (ADDR_W'(OFS_MASKRD) == addr) sel = SEL_MASKRD;
    else                                  sel = SEL_NONE;
  end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] set_bits,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_bits,
  output logic [NUM_IRQ-1:0] stat_q,
  output logic [NUM_IRQ-1:0] stat_d
);

  logic [NUM_IRQ-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  // An arriving cause wins over a same-cycle clear.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    always_comb stat_d[g] = set_bits[g] | (stat_q[g] & ~clr_eff[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  AST_CAUSE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((stat_q & $past(set_bits)) == $past(set_bits))); // R4

  AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_eff)) == '0)); // R3

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((~$past(stat_q) & stat_q) & ~$past(set_bits)) == '0)); // R2

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_we,
  input  logic               disarm_we,
  input  logic [NUM_IRQ-1:0] bits,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic [NUM_IRQ-1:0] mask_d
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    always_comb begin
      mask_d[g] = mask_q[g];
      if (arm_we && bits[g])         mask_d[g] = 1'b1;
      else if (disarm_we && bits[g]) mask_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
    arm_we |=> ((mask_q & $past(bits)) == $past(bits))); // R6

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    disarm_we |=> ((mask_q & $past(bits)) == '0)); // R7

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(arm_we || disarm_we) |=> $stable(mask_q)); // R11

endmodule

// File: rtl/spi_irq_regbank.sv
module spi_irq_regbank
  import spi_irq_pkg::*;
#(
  parameter int NUM_IRQ = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_IRQ-1:0] evt_pulse,
  input  logic [NUM_IRQ-1:0] lvl_src,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_IRQ;

  reg_sel_e           sel;
  logic [NUM_IRQ-1:0] wbits;
  logic [NUM_IRQ-1:0] stat_q, stat_d;
  logic [NUM_IRQ-1:0] mask_q, mask_d;

  assign wbits = wdata[NUM_IRQ-1:0];

  spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  spi_irq_status #(.NUM_IRQ(NUM_IRQ)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_bits (evt_pulse | lvl_src),
    .clr_we   (wr_en && (sel == SEL_STATUS)),
    .clr_bits (wbits),
    .stat_q   (stat_q),
    .stat_d   (stat_d)
  );

  spi_irq_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .arm_we    (wr_en && (sel == SEL_ARM)),
    .disarm_we (wr_en && (sel == SEL_DISARM)),
    .bits      (wbits),
    .mask_q    (mask_q),
    .mask_d    (mask_d)
  );

  // Registered read port; write-only and unmapped offsets read as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_STATUS: rdata <= {{PAD_W{1'b0}}, stat_q};
        SEL_MASKRD: rdata <= {{PAD_W{1'b0}}, mask_q};
        default:    rdata <= '0;
      endcase
    end
  end

  // Built from next-state values so the request lines up with the registers.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_d & mask_d);
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q)); // R10

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel != SEL_STATUS) && (sel != SEL_MASKRD)) |=> (rdata == '0)); // R9

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:NUM_IRQ] == '0); // R12

endmodule

// File: tb/spi_irq_regbank_test.sv
module spi_irq_regbank_test;

  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] evt_pulse = '0, lvl_src = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_irq_regbank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .lvl_src(lvl_src),
    .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 cause pulse, 3 irq-check
    logic [7:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h0C, 32'h7F,  32'h0,  4'd7},   // R7 disarm all
    '{2'd0, 8'h04, 32'h7F,  32'h0,  4'd3},   // R3 clear all
    '{2'd2, 8'h00, 32'h12,  32'h0,  4'd2},   // R2 causes 1 and 4
    '{2'd1, 8'h04, 32'h0,   32'h12, 4'd2},   // R2 latched
    '{2'd3, 8'h00, 32'h0,   32'h0,  4'd10},  // R10 masked
    '{2'd0, 8'h08, 32'h02,  32'h0,  4'd6},   // R6 arm bit 1
    '{2'd1, 8'h10, 32'h0,   32'h02, 4'd8},   // R8 mask view
    '{2'd3, 8'h00, 32'h0,   32'h1,  4'd10},  // R10 request
    '{2'd0, 8'h04, 32'h02,  32'h0,  4'd3},   // R3 clear bit 1
    '{2'd1, 8'h04, 32'h0,   32'h10, 4'd3},   // R3 bit 4 kept
    '{2'd3, 8'h00, 32'h0,   32'h0,  4'd10},  // R10 drops
    '{2'd0, 8'h08, 32'hFF70,32'h0,  4'd12},  // R12 high bits dropped
    '{2'd1, 8'h10, 32'h0,   32'h72, 4'd12},  // R12 R6
    '{2'd3, 8'h00, 32'h0,   32'h1,  4'd10},  // R10
    '{2'd0, 8'h0C, 32'h10,  32'h0,  4'd7},   // R7 disarm bit 4
    '{2'd1, 8'h10, 32'h0,   32'h62, 4'd7},   // R7
    '{2'd3, 8'h00, 32'h0,   32'h0,  4'd10},  // R10
    '{2'd1, 8'h08, 32'h0,   32'h0,  4'd9},   // R9
    '{2'd1, 8'h0C, 32'h0,   32'h0,  4'd9},   // R9
    '{2'd1, 8'h1C, 32'h0,   32'h0,  4'd9},   // R9 unmapped
    '{2'd0, 8'h10, 32'h7F,  32'h0,  4'd11},  // R11 write to view
    '{2'd1, 8'h10, 32'h0,   32'h62, 4'd11}   // R11 unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_evt(input logic [N-1:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    do_rd(8'h04, r); check("R1 status", r, 32'h0);
    do_rd(8'h10, r); check("R1 mask", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: do_wr(VEC[i].adr, VEC[i].dat);
        2'd1: begin do_rd(VEC[i].adr, r); check(tag, r, VEC[i].exp); end
        2'd2: do_evt(VEC[i].dat[N-1:0]);
        default: begin @(negedge clk); check(tag, {31'b0, irq}, VEC[i].exp); end
      endcase
    end

    // R4: cause on bit 3 collides with a clear of bit 3
    @(negedge clk); wr_en = 1'b1; addr = 8'h04; wdata = 32'h08; evt_pulse = 7'h08;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt_pulse = '0;
    do_rd(8'h04, r); check("R4 collide", r, 32'h18);

    // R5: level cause held across a clear, then released
    @(negedge clk); lvl_src = 7'h01;
    do_wr(8'h04, 32'h01);
    do_rd(8'h04, r); check("R5 held", r, 32'h19);
    @(negedge clk); lvl_src = '0;
    do_wr(8'h04, 32'h01);
    do_rd(8'h04, r); check("R5 released", r, 32'h18);

    // R10: arming a latched cause raises the request
    do_wr(8'h08, 32'h08);
    @(negedge clk); check("R10 armed", {31'b0, irq}, 32'h1);

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    do_rd(8'h10, r); check("R1 mask after reset", r, 32'h0);
    do_rd(8'h04, r); check("R1 status after reset", r, 32'h0);

    finish_run();
  end

endmodule